// File: doc/BRIEF.md
# High/Low Count Clock Divider

This block divides an input clock by an integer set as two separate counts instead of one ratio. The output stays high for a number of input cycles equal to the high count. It then stays low for a number of input cycles equal to the low count, and the pattern repeats. The period is therefore the sum of the two counts.

An edge flag holds the output high for an extra half input cycle, using the falling input edge. With an odd ratio this gives a duty cycle of exactly one half. A bypass flag sends the input clock straight to the output, which is divide-by-one. A configuration is presented on two 16-bit words and captured by a one-cycle load strobe. A parameter selects a single-word packing instead, in which both flags also sit in the first word.

A captured configuration is held back until the current output period has completed. A change of ratio therefore never produces a shortened pulse. When the divider is stopped or in bypass, there is no period in progress, so the held configuration is applied on the next input edge.

Top module: `hilo_clock_divider`

## Requirements
- R1: After reset, until a configuration is loaded, the output is held low.
- R2: In the first word, bits 5:0 give the low count and bits 11:6 give the high count. The output is high for `high` input cycles, then low for `low` input cycles, so the period is high plus low input cycles.
- R3: A count field of zero stands for 64 cycles, so high = 0 with low = 1 gives 64 cycles high in a 65-cycle period.
- R4: A configuration with both count fields zero and bypass clear is a zero ratio. It stops the divider, and the output stays low with no edges.
- R5: With the bypass flag set (second word bit 6), the output follows the input clock and the count fields have no effect.
- R6: With the edge flag set (second word bit 7), the output falls half an input cycle later. The high time is then high + 0.5 cycles and the low time is low − 0.5 cycles.
- R7: A configuration loaded while a period is in progress takes effect only at the next rising output edge. The period already in progress completes with the old counts.
- R8: With PACKED_FORM = 1, bit 12 of the first word is the bypass flag and bit 13 is the edge flag, and the second word is ignored. With PACKED_FORM = 0, bits 12 to 15 of the first word are ignored.
- R9: When the divider is stopped, a load sampled on one rising input edge starts the output high on the next rising input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that captures the configuration words |
| cfg_word0 | input | 16 | Count word: low count, high count (and both flags in packed form) |
| cfg_word1 | input | 16 | Flag word: bypass at bit 6, edge at bit 7 |
| clk_out | output | 1 | Divided clock |

## Verification
A corrupted phase counter would show up within one output period: the measured high or low time would be wrong, or a period would be cut short. A configuration register that updated at the wrong moment would show up in the boundary test: the high or low time of the period in progress when the load arrives would be shortened or lengthened. A half-cycle stage that failed to clear, or a stopped state that leaked a pulse, would show up as a rising output edge during the window in which the output must stay low.

// File: rtl/hlc_pkg.sv
`timescale 1ns/1ps
package hlc_pkg;
    // Width of one count field; a zero field encodes 2**CNT_W cycles.
    localparam int CNT_W  = 6;
    localparam int WORD_W = 16;
    localparam int CW     = CNT_W + 1;

    typedef struct packed {
        logic [CW-1:0] high;     // expanded high count, 1 .. 2**CNT_W
        logic [CW-1:0] low;      // expanded low count, 1 .. 2**CNT_W
        logic          bypass;
        logic          edge_en;
        logic          valid;    // non-zero ratio or bypass
    } div_cfg_t;

    function automatic logic [CW-1:0] expand_cnt(input logic [CNT_W-1:0] raw);
        expand_cnt = (raw == '0) ? CW'(1 << CNT_W) : {1'b0, raw};
    endfunction
endpackage

// File: rtl/hlc_cfg_decode.sv
`timescale 1ns/1ps
module hlc_cfg_decode
    import hlc_pkg::*;
#(
    parameter bit PACKED_FORM = 1'b0
) (
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    output div_cfg_t          cfg
);
    localparam int LO_LSB   = 0;
    localparam int HI_LSB   = CNT_W;
    localparam int PK_BYP   = 2 * CNT_W;
    localparam int PK_EDGE  = 2 * CNT_W + 1;
    localparam int SEP_BYP  = 6;
    localparam int SEP_EDGE = 7;

    logic [CNT_W-1:0] lo_raw;
    logic [CNT_W-1:0] hi_raw;
    logic             byp;
    logic             edg;

    assign lo_raw = word0[LO_LSB +: CNT_W];
    assign hi_raw = word0[HI_LSB +: CNT_W];

    generate
        if (PACKED_FORM) begin : g_packed
            logic unused_w1;
            assign unused_w1 = ^word1;
            assign byp = word0[PK_BYP];
            assign edg = word0[PK_EDGE];
        end else begin : g_split
            assign byp = word1[SEP_BYP];
            assign edg = word1[SEP_EDGE];
        end
    endgenerate

    always_comb begin
        cfg.high    = expand_cnt(hi_raw);
        cfg.low     = expand_cnt(lo_raw);
        cfg.bypass  = byp;
        cfg.edge_en = edg & ~byp;
        cfg.valid   = byp | (hi_raw != '0) | (lo_raw != '0);
    end
endmodule

// File: rtl/hlc_count_core.sv
`timescale 1ns/1ps
module hlc_count_core
    import hlc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  div_cfg_t cfg_in,
    output logic     hi_o,
    output div_cfg_t act_o
);
    typedef struct packed {
        logic          hi;
        logic [CW-1:0] cnt;
        div_cfg_t      act;
        div_cfg_t      pend;
        logic          pend_v;
    } core_st_t;

    core_st_t st_d, st_q;
    div_cfg_t nxt_cfg;
    logic     idle;

    always_comb begin
        st_d    = st_q;
        nxt_cfg = st_q.pend_v ? st_q.pend : st_q.act;
        idle    = !st_q.act.valid || st_q.act.bypass;
        if (load) begin
            st_d.pend   = cfg_in;
            st_d.pend_v = 1'b1;
        end
        if (idle) begin
            st_d.hi = 1'b0;
            if (st_q.pend_v) begin
                st_d.act    = st_q.pend;
                st_d.pend_v = load;
                if (st_q.pend.valid && !st_q.pend.bypass) begin
                    st_d.hi  = 1'b1;
                    st_d.cnt = st_q.pend.high;
                end
            end
        end else if (st_q.cnt == CW'(1)) begin
            if (st_q.hi) begin
                st_d.hi  = 1'b0;
                st_d.cnt = st_q.act.low;
            end else begin
                // period boundary: the held configuration becomes active
                if (st_q.pend_v) begin
                    st_d.act    = st_q.pend;
                    st_d.pend_v = load;
                end
                if (nxt_cfg.valid && !nxt_cfg.bypass) begin
                    st_d.hi  = 1'b1;
                    st_d.cnt = nxt_cfg.high;
                end else begin
                    st_d.hi = 1'b0;
                end
            end
        end else begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o  = st_q.hi;
    assign act_o = st_q.act;

    // a running phase counter counts down by one with the level held
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!idle && st_q.cnt > CW'(1)) |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)) && $stable(st_q.hi));

    // the running count never leaves 1 .. 2**CNT_W
    p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
        !idle |-> (st_q.cnt >= CW'(1)) && (st_q.cnt <= CW'(1 << CNT_W)));

    // the active configuration changes only at a period boundary
    p_cfg_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        (!idle && !(st_q.cnt == CW'(1) && !st_q.hi)) |=> st_q.act == $past(st_q.act));

    // a stopped divider never drives its level high
    p_stop_low_r4: assert property (@(posedge clk) disable iff (rst)
        !st_q.act.valid |-> !st_q.hi);
endmodule

// File: rtl/hlc_edge_stage.sv
`timescale 1ns/1ps
module hlc_edge_stage (
    input  logic clk,
    input  logic rst,
    input  logic hi_i,
    input  logic edge_en,
    output logic div_o
);
    logic neg_d, neg_q;

    always_comb begin
        neg_d = hi_i;
    end

    // falling-edge copy keeps the level up for half an extra input cycle
    always_ff @(negedge clk) begin
        if (rst) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= neg_d;
        end
    end

    assign div_o = hi_i | (edge_en & neg_q);
endmodule

// File: rtl/hilo_clock_divider.sv
`timescale 1ns/1ps
module hilo_clock_divider
    import hlc_pkg::*;
#(
    parameter bit PACKED_FORM = 1'b0
) (
    input  logic              clk_in,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [WORD_W-1:0] cfg_word0,
    input  logic [WORD_W-1:0] cfg_word1,
    output logic              clk_out
);
    div_cfg_t dec_cfg;
    div_cfg_t act_cfg;
    logic     hi_lvl;
    logic     div_lvl;

    hlc_cfg_decode #(.PACKED_FORM(PACKED_FORM)) u_decode (
        .word0 (cfg_word0),
        .word1 (cfg_word1),
        .cfg   (dec_cfg)
    );

    hlc_count_core u_core (
        .clk    (clk_in),
        .rst    (rst),
        .load   (cfg_load),
        .cfg_in (dec_cfg),
        .hi_o   (hi_lvl),
        .act_o  (act_cfg)
    );

    hlc_edge_stage u_edge (
        .clk     (clk_in),
        .rst     (rst),
        .hi_i    (hi_lvl),
        .edge_en (act_cfg.edge_en),
        .div_o   (div_lvl)
    );

    assign clk_out = act_cfg.bypass ? clk_in : div_lvl;
endmodule

// File: tb/hilo_clock_divider_tb.sv
`timescale 1ns/1ps
module hilo_clock_divider_tb;
    localparam real TCK = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0, pk_load = 1'b0;
    logic [15:0] w0 = '0, w1 = '0, pk_w0 = '0, pk_w1 = '0;
    logic        clk_out, pk_out;
    int          n_chk = 0, n_fail = 0, rises = 0;

    always #(TCK / 2.0) clk = ~clk;
    always @(posedge clk_out) rises++;

    hilo_clock_divider u_dut (.clk_in(clk), .rst(rst), .cfg_load(load),
        .cfg_word0(w0), .cfg_word1(w1), .clk_out(clk_out));
    hilo_clock_divider #(.PACKED_FORM(1'b1)) u_dut_pk (.clk_in(clk), .rst(rst),
        .cfg_load(pk_load), .cfg_word0(pk_w0), .cfg_word1(pk_w1), .clk_out(pk_out));

    task automatic check(input string req, input real act, input real exp);
        n_chk++;
        if (act > exp + 0.01 || act < exp - 0.01) begin
            n_fail++;
            $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk); w0 = a; w1 = b; load = 1'b1;
        @(negedge clk); load = 1'b0;
    endtask

    // settle on a new-config boundary, then time one high phase and one period
    task automatic measure(input string req, input real exp_per, input real exp_hi);
        realtime t0, t1, t2;
        @(posedge clk_out);
        @(posedge clk_out); t0 = $realtime;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        check({req, " period"}, t2 - t0, exp_per);
        check({req, " high"},   t1 - t0, exp_hi);
    endtask

    task automatic t_reset_r1();
        repeat (3) @(negedge clk);
        check("R1 in reset", real'(clk_out), 0.0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check("R1 idle after reset", real'(clk_out), 0.0);
        check("R1 no edges", real'(rises), 0.0);
    endtask

    task automatic t_start_r9();
        load_cfg(16'h0041, 16'h0000);            // H1 L1, loaded with the output stopped
        // load sampled on the edge before this negedge; start on the next rising edge
        check("R9 still low before start", real'(clk_out), 0.0);
        @(posedge clk); #1;
        check("R9 high one edge after load", real'(clk_out), 1.0);
    endtask

    task automatic t_basic_r2();
        load_cfg(16'h0041, 16'h0000);
        measure("R2 ratio 2", 2 * TCK, 1 * TCK);
        load_cfg(16'h00C4, 16'h0000);            // H3 L4
        measure("R2 ratio 7", 7 * TCK, 3 * TCK);
    endtask

    task automatic t_edge_r6();
        load_cfg(16'h0042, 16'h0080);            // H1 L2 + edge
        measure("R6 ratio 3 edge", 3 * TCK, 1.5 * TCK);
        load_cfg(16'h00C4, 16'h0080);            // H3 L4 + edge
        measure("R6 ratio 7 edge", 7 * TCK, 3.5 * TCK);
    endtask

    task automatic t_large_r3();
        load_cfg(16'h0820, 16'h0000);            // H32 L32
        measure("R3 ratio 64", 64 * TCK, 32 * TCK);
        load_cfg(16'h0001, 16'h0000);            // H0 -> 64, L1
        measure("R3 zero high field", 65 * TCK, 64 * TCK);
    endtask

    task automatic t_bypass_r5();
        load_cfg(16'h00C4, 16'h0040);            // counts present but bypassed
        measure("R5 bypass", TCK, TCK / 2.0);
        @(posedge clk); #1;
        check("R5 follows high", real'(clk_out), 1.0);
        @(negedge clk); #1;
        check("R5 follows low", real'(clk_out), 0.0);
    endtask

    task automatic t_zero_r4();
        int r0;
        load_cfg(16'h0000, 16'h0000);
        repeat (4) @(negedge clk);
        r0 = rises;
        repeat (200) @(negedge clk);
        check("R4 zero ratio no edges", real'(rises - r0), 0.0);
        check("R4 zero ratio low", real'(clk_out), 0.0);
    endtask

    task automatic t_boundary_r7();
        realtime t0, t1, t2, t3;
        load_cfg(16'h0208, 16'h0000);            // H8 L8
        @(posedge clk_out);
        @(posedge clk_out); t0 = $realtime;
        repeat (2) @(negedge clk);
        load_cfg(16'h0041, 16'h0000);            // H1 L1 arrives mid-high
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        @(negedge clk_out); t3 = $realtime;
        check("R7 old high kept", t1 - t0, 8 * TCK);
        check("R7 old low kept",  t2 - t1, 8 * TCK);
        check("R7 new high",      t3 - t2, 1 * TCK);
    endtask

    task automatic t_packing_r8();
        realtime t0, t1, t2;
        load_cfg(16'h1041, 16'h0000);            // bit 12 set, split form: not bypass
        measure("R8 split ignores bit12", 2 * TCK, 1 * TCK);
        @(negedge clk);
        pk_w0 = 16'h2083; pk_w1 = 16'h00C0; pk_load = 1'b1;   // H2 L3 + edge, word1 junk
        @(negedge clk); pk_load = 1'b0;
        @(posedge pk_out);
        @(posedge pk_out); t0 = $realtime;
        @(negedge pk_out); t1 = $realtime;
        @(posedge pk_out); t2 = $realtime;
        check("R8 packed period", t2 - t0, 5 * TCK);
        check("R8 packed edge high", t1 - t0, 2.5 * TCK);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_start_r9();
        t_basic_r2();
        t_edge_r6();
        t_large_r3();
        t_bypass_r5();
        t_zero_r4();
        t_boundary_r7();
        t_packing_r8();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule